// File: doc/BRIEF.md
# Bidirectional Common Scan Driver Logic

This block is the digital core of a row (common) driver for a passive-matrix display with up to 162 outputs. A one-bit line marker enters at one end of a shift register and advances by one position for each falling edge of the line clock. A direction input decides which serial port takes the marker in and which one shows it leaving at the far end. The block samples the line clock with the system clock, so a falling edge takes effect at the first system clock edge that sees the line clock low after it was high.

A two-bit mode input selects 162, 160 or 120 active positions. Positions that are not used are left out of the shift path, so the marker crosses the active span in exactly as many line clocks as there are active outputs. Unused outputs always show the non-select code. Each active output turns its register bit, the alternating signal and the display-enable input into a two-bit drive-level code: 00 is the middle (non-select) level, 01 is the high level and 10 is the low level. Level shifting and the analog output stages sit outside this block.

Top module: `cdrv_common_scan`

## Requirements
- R1: After a synchronous active-low reset every register bit is 0, every output code is 00, and both serial outputs are 0.
- R2: The register moves by exactly one position at the first system clock edge where `line_clk` is sampled low after it was sampled high. It holds its contents while `line_clk` stays high or stays low, whatever the serial inputs do.
- R3: With `dir_fwd`=1 the marker enters at `port_a_in` and moves toward higher output numbers, and `port_b_oe`=1 and `port_a_oe`=0. With `dir_fwd`=0 it enters at `port_b_in` and moves toward lower numbers, and `port_a_oe`=1 and `port_b_oe`=0. `port_a_out` always shows the bit of the lowest active position and `port_b_out` the bit of the highest active position.
- R4: With `mode`=00, and also with the unassigned value 11, all outputs X1..X162 are active, and a marker entered on one shift reaches the far serial output after 162 shifts in total.
- R5: With `mode`=01, X1 and X162 are bypassed and give code 00, and a marker reaches the far serial output after 160 shifts.
- R6: With `mode`=10, X1, X62..X101 and X162 are bypassed and give code 00. The marker passes directly between X61 and X102 and reaches the far serial output after 120 shifts.
- R7: While `disp_en`=1, an active output whose bit is 1 gives 01 when `alt_m`=0 and 10 when `alt_m`=1. An output whose bit is 0 gives 00. The code 11 never appears. A change of `alt_m` shows in the same cycle.
- R8: While `disp_en`=0, every output gives 00. Shifting continues, and the register contents show again once `disp_en` returns to 1.
- R9: On a shift, a position that is bypassed in the current mode is cleared to 0. Output Xn occupies bits [2n-1:2n-2] of `lvl_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_clk | input | 1 | Line clock. A sampled falling edge shifts the marker |
| dir_fwd | input | 1 | 1: marker enters at port A and moves toward X162. 0: the reverse |
| mode | input | 2 | 00/11: 162 outputs, 01: 160 outputs, 10: 120 outputs |
| alt_m | input | 1 | Alternating drive polarity |
| disp_en | input | 1 | 0 forces every output to the middle level |
| port_a_in | input | 1 | Serial marker input at the X1 end |
| port_a_out | output | 1 | Bit of the lowest active position |
| port_a_oe | output | 1 | Port A acts as an output |
| port_b_in | input | 1 | Serial marker input at the X162 end |
| port_b_out | output | 1 | Bit of the highest active position |
| port_b_oe | output | 1 | Port B acts as an output |
| lvl_out | output | 324 | Two-bit level code per output, X1 in the lowest bits |

## Verification
A shift edge can land in the same cycle as a change of direction or output mode. The new direction or span then decides where every bit moves and which positions get cleared. The random phase changes `dir_fwd` and `mode` at the same moment it pulls `line_clk` low. A bench model then moves its bits along the list of active positions for the new settings, and the bench compares every level code and both serial outputs after each shift.

// File: rtl/cdrv_pkg.sv
// Shared types for the common scan driver: drive-level codes and span modes.
package cdrv_pkg;
    typedef enum logic [1:0] {
        LVL_MID  = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_LOW  = 2'b10
    } lvl_e;

    typedef enum logic [1:0] {
        SPAN_FULL  = 2'b00,
        SPAN_TRIM  = 2'b01,
        SPAN_SPLIT = 2'b10,
        SPAN_SPARE = 2'b11
    } span_e;
endpackage

// File: rtl/cdrv_line_edge.sv
// Line clock falling-edge detector.
// Samples the asynchronous-to-core line clock once per system clock and
// raises a one-cycle strobe on the first low sample after a high one.
// Assumes line_clk is already synchronised or slow relative to clk.
module cdrv_line_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk,
    output logic fall
);
    logic cl_q;

    // Remember the previous line clock sample.
    always_ff @(posedge clk) begin
        if (!rst_n) cl_q <= 1'b0;
        else        cl_q <= line_clk;
    end

    assign fall = cl_q & ~line_clk;

    // R2: a held-low line clock gives only one strobe
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/cdrv_span_cfg.sv
// Span decoder: turns the mode code into the set of active positions,
// the indices of the two end positions, and whether the middle band is
// bypassed. Positions are numbered 0..N_OUT-1 (output X1 is position 0).
// Assumes 0 < GAP_LO <= GAP_HI < N_OUT-2.
module cdrv_span_cfg #(
    parameter int N_OUT  = 162,
    parameter int GAP_LO = 61,
    parameter int GAP_HI = 100,
    localparam int IW    = $clog2(N_OUT)
) (
    input  logic [1:0]       mode,
    output logic [N_OUT-1:0] active,
    output logic [IW-1:0]    first_idx,
    output logic [IW-1:0]    last_idx,
    output logic             gap_on
);
    import cdrv_pkg::*;

    logic trim;

    // Decode which end and middle trims the mode asks for.
    always_comb begin
        trim      = (span_e'(mode) == SPAN_TRIM) || (span_e'(mode) == SPAN_SPLIT);
        gap_on    = (span_e'(mode) == SPAN_SPLIT);
        first_idx = trim ? IW'(1) : IW'(0);
        last_idx  = trim ? IW'(N_OUT - 2) : IW'(N_OUT - 1);
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_act
        if (i == 0 || i == N_OUT - 1) begin : g_end
            assign active[i] = ~trim;
        end else if (i >= GAP_LO && i <= GAP_HI) begin : g_gap
            assign active[i] = ~gap_on;
        end else begin : g_core
            assign active[i] = 1'b1;
        end
    end
endmodule

// File: rtl/cdrv_shift_chain.sv
// Bidirectional marker shift register with mode-dependent bypass.
// On each strobe every active position takes the bit of its nearest active
// neighbour upstream, the entry position takes the serial input, and every
// bypassed position is cleared. Assumes the span inputs come from
// cdrv_span_cfg with the same parameters.
module cdrv_shift_chain #(
    parameter int N_OUT  = 162,
    parameter int GAP_LO = 61,
    parameter int GAP_HI = 100,
    localparam int IW    = $clog2(N_OUT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             fwd,
    input  logic             din,
    input  logic [N_OUT-1:0] active,
    input  logic [IW-1:0]    first_idx,
    input  logic [IW-1:0]    last_idx,
    input  logic             gap_on,
    output logic [N_OUT-1:0] q,
    output logic             head_bit,
    output logic             tail_bit
);
    logic [N_OUT-1:0] nxt;

    for (genvar i = 0; i < N_OUT; i++) begin : g_bit
        logic src_f;
        logic src_r;

        // Source when moving toward higher positions.
        if (i == 0) begin : g_f0
            assign src_f = din;
        end else if (i == GAP_HI + 1) begin : g_fgap
            assign src_f = (first_idx == IW'(i)) ? din :
                           (gap_on ? q[GAP_LO-1] : q[i-1]);
        end else begin : g_fn
            assign src_f = (first_idx == IW'(i)) ? din : q[i-1];
        end

        // Source when moving toward lower positions.
        if (i == N_OUT - 1) begin : g_rn
            assign src_r = din;
        end else if (i == GAP_LO - 1) begin : g_rgap
            assign src_r = (last_idx == IW'(i)) ? din :
                           (gap_on ? q[GAP_HI+1] : q[i+1]);
        end else begin : g_rm
            assign src_r = (last_idx == IW'(i)) ? din : q[i+1];
        end

        assign nxt[i] = active[i] & (fwd ? src_f : src_r);
    end

    // Advance the register one position per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= nxt;
    end

    assign head_bit = q[first_idx];
    assign tail_bit = q[last_idx];

    // R2: no strobe, no movement
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(q));
    // R3/R4: forward step in the full span moves every bit up by one
    assert_fwd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && fwd && first_idx == IW'(0) && last_idx == IW'(N_OUT-1))
        |=> q[N_OUT-1:1] == $past(q[N_OUT-2:0]));
    // R3: reverse step in the full span moves every bit down by one
    assert_rev_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !fwd && first_idx == IW'(0) && last_idx == IW'(N_OUT-1))
        |=> q[N_OUT-2:0] == $past(q[N_OUT-1:1]));
    // R6/R9: in the split span the middle band is empty after a shift
    assert_gap_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && gap_on) |=> q[GAP_HI:GAP_LO] == '0);
endmodule

// File: rtl/cdrv_level_map.sv
// Per-output drive-level encoder.
// Combines each position's marker bit with the alternating signal and the
// display enable into a two-bit level code; bypassed positions and a dark
// display give the middle level. Purely combinational; clk and rst_n only
// time the embedded checks.
module cdrv_level_map #(
    parameter int N_OUT = 162
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_OUT-1:0]   bits,
    input  logic [N_OUT-1:0]   active,
    input  logic               alt_m,
    input  logic               disp_en,
    output logic [2*N_OUT-1:0] lvl
);
    import cdrv_pkg::*;

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        lvl_e code;

        // Select the level for this output.
        always_comb begin
            if (!disp_en || !active[i] || !bits[i]) code = LVL_MID;
            else if (alt_m)                         code = LVL_LOW;
            else                                    code = LVL_HIGH;
        end

        assign lvl[2*i +: 2] = code;

        // R7: the unused code never reaches an output
        assert_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
            lvl[2*i +: 2] != 2'b11);
    end

    // R8: a dark display shows only the middle level
    assert_dark_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> lvl == '0);
endmodule

// File: rtl/cdrv_common_scan.sv
// Common scan driver core (top).
// Detects falling line clock edges, shifts a line marker through the
// active span in the selected direction, exposes both span ends on the
// serial ports with direction-dependent enables, and encodes a level code
// for every output. Assumes line_clk toggles slower than clk/2.
module cdrv_common_scan #(
    parameter int N_OUT  = 162,
    parameter int GAP_LO = 61,
    parameter int GAP_HI = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_clk,
    input  logic               dir_fwd,
    input  logic [1:0]         mode,
    input  logic               alt_m,
    input  logic               disp_en,
    input  logic               port_a_in,
    output logic               port_a_out,
    output logic               port_a_oe,
    input  logic               port_b_in,
    output logic               port_b_out,
    output logic               port_b_oe,
    output logic [2*N_OUT-1:0] lvl_out
);
    localparam int IW = $clog2(N_OUT);

    logic             fall;
    logic [N_OUT-1:0] active;
    logic [IW-1:0]    first_idx;
    logic [IW-1:0]    last_idx;
    logic             gap_on;
    logic [N_OUT-1:0] q;
    logic             din;

    cdrv_line_edge i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_clk (line_clk),
        .fall     (fall)
    );

    cdrv_span_cfg #(.N_OUT(N_OUT), .GAP_LO(GAP_LO), .GAP_HI(GAP_HI)) i_span (
        .mode      (mode),
        .active    (active),
        .first_idx (first_idx),
        .last_idx  (last_idx),
        .gap_on    (gap_on)
    );

    // Pick the serial input on the entry side.
    assign din = dir_fwd ? port_a_in : port_b_in;

    cdrv_shift_chain #(.N_OUT(N_OUT), .GAP_LO(GAP_LO), .GAP_HI(GAP_HI)) i_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (fall),
        .fwd       (dir_fwd),
        .din       (din),
        .active    (active),
        .first_idx (first_idx),
        .last_idx  (last_idx),
        .gap_on    (gap_on),
        .q         (q),
        .head_bit  (port_a_out),
        .tail_bit  (port_b_out)
    );

    // The far end of the chosen direction drives its port.
    assign port_a_oe = ~dir_fwd;
    assign port_b_oe = dir_fwd;

    cdrv_level_map #(.N_OUT(N_OUT)) i_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .bits    (q),
        .active  (active),
        .alt_m   (alt_m),
        .disp_en (disp_en),
        .lvl     (lvl_out)
    );

    // R6: a middle-band output stays at the middle level in the split span
    assert_band_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |-> lvl_out[2*((GAP_LO+GAP_HI)/2) +: 2] == 2'b00);
    // R5: the trimmed ends stay at the middle level in the reduced spans
    assert_end_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 || mode == 2'b10) |->
        (lvl_out[1:0] == 2'b00 && lvl_out[2*N_OUT-1 -: 2] == 2'b00));
endmodule

// File: tb/test_cdrv_common_scan.sv
`timescale 1ns/1ps
module test_cdrv_common_scan;
    localparam int N = 162;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           line_clk = 1'b1;
    logic           dir_fwd = 1'b1;
    logic [1:0]     mode = 2'b00;
    logic           alt_m = 1'b0;
    logic           disp_en = 1'b1;
    logic           port_a_in = 1'b0;
    logic           port_b_in = 1'b0;
    logic           port_a_out, port_a_oe, port_b_out, port_b_oe;
    logic [2*N-1:0] lvl_out;

    int total = 0;
    int bad = 0;
    logic [N-1:0] ref_q = '0;

    always #2 clk = ~clk;

    cdrv_common_scan i_cdrv_common_scan (
        .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .dir_fwd(dir_fwd),
        .mode(mode), .alt_m(alt_m), .disp_en(disp_en),
        .port_a_in(port_a_in), .port_a_out(port_a_out), .port_a_oe(port_a_oe),
        .port_b_in(port_b_in), .port_b_out(port_b_out), .port_b_oe(port_b_oe),
        .lvl_out(lvl_out)
    );

    // Position i is used for mode md (X1 = position 0).
    function automatic logic is_act(int i, logic [1:0] md);
        if (md == 2'b01) return (i != 0 && i != N-1);
        if (md == 2'b10) return (i != 0 && i != N-1 && !(i >= 61 && i <= 100));
        return 1'b1;
    endfunction

    function automatic int act_count(logic [1:0] md);
        int c = 0;
        for (int i = 0; i < N; i++) if (is_act(i, md)) c++;
        return c;
    endfunction

    function automatic int lo_end(logic [1:0] md);
        for (int i = 0; i < N; i++) if (is_act(i, md)) return i;
        return 0;
    endfunction

    function automatic int hi_end(logic [1:0] md);
        for (int i = N-1; i >= 0; i--) if (is_act(i, md)) return i;
        return 0;
    endfunction

    // Expected level codes: 00 middle, 01 high, 10 low.
    function automatic logic [2*N-1:0] exp_lvl(logic [N-1:0] b, logic [1:0] md,
                                               logic m, logic en);
        logic [2*N-1:0] v = '0;
        for (int i = 0; i < N; i++)
            if (en && is_act(i, md) && b[i]) v[2*i +: 2] = m ? 2'b10 : 2'b01;
        return v;
    endfunction

    // Move the model along the list of active positions.
    task automatic model_shift(input logic d);
        int idx[N];
        int c = 0;
        logic [N-1:0] nq = '0;
        for (int i = 0; i < N; i++) if (is_act(i, mode)) begin idx[c] = i; c++; end
        if (dir_fwd) begin
            nq[idx[0]] = d;
            for (int k = 1; k < c; k++) nq[idx[k]] = ref_q[idx[k-1]];
        end else begin
            nq[idx[c-1]] = d;
            for (int k = 0; k < c-1; k++) nq[idx[k]] = ref_q[idx[k+1]];
        end
        ref_q = nq;
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        logic [2*N-1:0] e;
        e = exp_lvl(ref_q, mode, alt_m, disp_en);
        total++;
        if (lvl_out !== e) begin
            bad++;
            $display("FAIL %s lvl: actual=%h expected=%h", tag, lvl_out, e);
        end
        chk_bit(port_a_out, ref_q[lo_end(mode)], {tag, " R3 port_a_out"});
        chk_bit(port_b_out, ref_q[hi_end(mode)], {tag, " R3 port_b_out"});
        chk_bit(port_b_oe, dir_fwd, {tag, " R3 port_b_oe"});
        chk_bit(port_a_oe, ~dir_fwd, {tag, " R3 port_a_oe"});
    endtask

    // One line clock pulse; direction and mode change at the falling edge.
    task automatic step(input logic d, input logic [1:0] md, input logic dr, input string tag);
        @(negedge clk);
        mode = md;
        dir_fwd = dr;
        if (dr) begin port_a_in = d; port_b_in = 1'($urandom()); end
        else    begin port_b_in = d; port_a_in = 1'($urandom()); end
        line_clk = 1'b0;
        @(posedge clk);
        model_shift(d);
        @(negedge clk);
        line_clk = 1'b1;
        chk_all(tag);
    endtask

    // Marker transit across the span for one mode and direction.
    task automatic transit(input logic [1:0] md, input logic dr, input string tag);
        int n = act_count(md);
        for (int k = 0; k < N; k++) step(1'b0, md, dr, tag);
        step(1'b1, md, dr, tag);
        for (int k = 2; k <= n; k++) begin
            step(1'b0, md, dr, tag);
            if (k == n - 1) chk_bit(dr ? port_b_out : port_a_out, 1'b0, {tag, " early"});
            if (k == n)     chk_bit(dr ? port_b_out : port_a_out, 1'b1, {tag, " arrival"});
        end
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [N-1:0] held;
        void'($urandom(32'd20417));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_all("R1 reset");
        chk_bit(port_a_out, 1'b0, "R1 port_a_out");
        chk_bit(port_b_out, 1'b0, "R1 port_b_out");

        // R4, R5, R6 with R3: transit length per mode and direction
        transit(2'b00, 1'b1, "R4 full fwd");
        transit(2'b00, 1'b0, "R4 full rev");
        transit(2'b11, 1'b1, "R4 spare fwd");
        transit(2'b01, 1'b1, "R5 trim fwd");
        transit(2'b01, 1'b0, "R5 trim rev");
        transit(2'b10, 1'b1, "R6 split fwd");
        transit(2'b10, 1'b0, "R6 split rev");

        // R6/R9: a marker crossing the middle band lands at X102 next
        for (int k = 0; k < N; k++) step(1'b0, 2'b10, 1'b1, "R9 flush");
        step(1'b1, 2'b10, 1'b1, "R9 inject");
        for (int k = 0; k < 59; k++) step(1'b0, 2'b10, 1'b1, "R6 walk");
        chk_bit(lvl_out[2*60 +: 2] == 2'b01, 1'b1, "R6 marker at X61");
        step(1'b0, 2'b10, 1'b1, "R6 hop");
        chk_bit(lvl_out[2*101 +: 2] == 2'b01, 1'b1, "R6 marker at X102");

        // R9: switching to the split span clears band bits on the next shift
        for (int k = 0; k < 90; k++) step(1'b1, 2'b00, 1'b1, "R9 fill");
        step(1'b1, 2'b10, 1'b1, "R9 clear");
        chk_bit(lvl_out[2*61 +: 80] == '0, 1'b1, "R9 band cleared");

        // R2: line clock held high, inputs wiggle, nothing moves
        held = ref_q;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            port_a_in = 1'($urandom());
            port_b_in = 1'($urandom());
        end
        chk_all("R2 held high");
        chk_bit(ref_q == held, 1'b1, "R2 model unchanged");

        // R2: line clock held low gives a single shift
        @(negedge clk);
        mode = 2'b00;
        dir_fwd = 1'b1;
        port_a_in = 1'b1;
        line_clk = 1'b0;
        @(posedge clk);
        model_shift(1'b1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            port_a_in = 1'($urandom());
        end
        chk_all("R2 held low");
        @(negedge clk);
        line_clk = 1'b1;

        // R7: polarity and same-cycle response of alt_m
        @(negedge clk);
        alt_m = 1'b1;
        #0.5;
        chk_all("R7 alt high");
        chk_bit(lvl_out[1:0] == 2'b10, 1'b1, "R7 X1 low level");
        alt_m = 1'b0;
        #0.5;
        chk_all("R7 alt low");
        chk_bit(lvl_out[1:0] == 2'b01, 1'b1, "R7 X1 high level");

        // R8: dark display, shifting continues, contents reappear
        disp_en = 1'b0;
        #0.5;
        chk_bit(lvl_out == '0, 1'b1, "R8 dark");
        step(1'b1, 2'b00, 1'b1, "R8 dark shift");
        step(1'b0, 2'b00, 1'b1, "R8 dark shift");
        @(negedge clk);
        disp_en = 1'b1;
        #0.5;
        chk_all("R8 restored");

        // R7 with R3/R9: random mix, changes coinciding with the falling edge
        for (int k = 0; k < 1500; k++) begin
            logic [1:0] md;
            logic       dr;
            md = ($urandom() % 8 == 0) ? 2'($urandom()) : mode;
            dr = ($urandom() % 6 == 0) ? ~dir_fwd : dir_fwd;
            alt_m = 1'($urandom());
            disp_en = ($urandom() % 10) != 0;
            step(($urandom() % 8) == 0, md, dr, "R7 random");
        end

        finish_run();
    end
endmodule